// File: doc/BRIEF.md
# Two-Angle Sequential CORDIC Rotator

This block turns a signed complex sample (x, y) clockwise by one of the eight twiddle angles of a sixteen-point FFT, from 0° to 157.5° in 22.5° steps. The caller does not supply an angle. It supplies a three-bit twiddle index. A small table turns the index into two repeat counts. A sequencer then applies a coarse 45° micro-rotation as many times as the first count asks, and after that a fine arctan(1/8) ≈ 7.125° micro-rotation as many times as the second count asks. The fine step needs only a fixed shift of three places. The coarse step is followed by a fixed gain of about 0.707, which is built from shifts and adds.

The block is meant to sit beside a butterfly adder in a small sequential FFT. The caller pulses `start` with an index and a sample. The rotated sample comes back one result per request, together with a single-cycle `done`. The counts are stored as sign and magnitude, so no negation logic is needed to read them. Angles up to 180° are covered in one pass, with no quadrant pre-rotation.

Top module: `c2r_rotator`

## Requirements
- R1: While `rst` is high, and after it is released until the first result, `done` is 0 and `x_out` and `y_out` are 0.
- R2: For index i, the number of 45° steps is i>>1 and the number of 7.125° steps is 3 when i is odd and 0 when i is even. When `start` is accepted at a clock edge, `done` is high in the cycle that follows edge (i>>1) + (3 when i is odd, else 0) + 1 after that edge.
- R3: A 45° step maps (x, y) to (S(x+y), S(y−x)). S(v) is (v>>>1)+(v>>>3)+(v>>>4)+(v>>>6)+(v>>>8), with each shift an arithmetic shift that rounds toward minus infinity. This is the mantissa 0.10110101b.
- R4: A 7.125° step maps (x, y) to (x + (y>>>3), y − (x>>>3)), using the old x and y on both sides, with no gain correction.
- R5: Every 45° step of a request comes before every 7.125° step of the same request.
- R6: Index 0 returns the input sample unchanged, sign-extended to 17 bits, with `done` one cycle after the accepting edge.
- R7: `done` is high for exactly one cycle per accepted request. `x_out` and `y_out` change only at the edge that raises `done`, and otherwise hold their last value.
- R8: `start` is accepted only when the block is idle, which includes the cycle in which `done` is high. A `start` seen while a rotation is running has no effect on that rotation's result or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a rotation of `x_in`,`y_in` by twiddle `idx` |
| idx | input | 3 | Twiddle index, angle = idx × 22.5° |
| x_in | input | 16 | Real part of the input sample, two's complement |
| y_in | input | 16 | Imaginary part of the input sample, two's complement |
| done | output | 1 | One-cycle pulse marking a new result |
| x_out | output | 17 | Real part of the rotated sample, one guard bit |
| y_out | output | 17 | Imaginary part of the rotated sample, one guard bit |

## Verification
Every index is driven with several samples: a single non-zero axis, both full-scale corners with equal signs, a mixed full-scale pair and an irregular mid-range pair. These patterns expose a wrong rotation direction, a swapped coarse and fine order, and a lost carry or guard bit in the coarse sum. Index 0 separates a pass-through with correct timing from any spurious step. The odd indices separate the fine-step arithmetic and its missing gain from the coarse path. A final phase holds `start` high with changing operands. It shows that requests are taken only when the block is idle, including back to back in the `done` cycle, and that a busy rotation is never reloaded.

// File: rtl/c2r_pkg.sv
package c2r_pkg;

  // Controller phases.
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } c2r_state_e;

  // Micro-rotation kind selected by the sequencer.
  typedef enum logic [0:0] {
    STEP_COARSE = 1'b0,   // arctan(1)
    STEP_FINE   = 1'b1    // arctan(2^-FINE_SH)
  } c2r_step_e;

  // 0.10110101b : fixed gain applied after each coarse step.
  localparam int unsigned C2R_GAIN_FRAC_W = 8;
  localparam logic [C2R_GAIN_FRAC_W-1:0] C2R_GAIN_MANT = 8'b1011_0101;

endpackage

// File: rtl/c2r_count_table.sv
module c2r_count_table #(
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 2,
  parameter int FINE_REPS = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic             coarse_neg,
  output logic [CNT_W-1:0] coarse_mag,
  output logic             fine_neg,
  output logic [CNT_W-1:0] fine_mag
);

  localparam int DEPTH   = 1 << IDX_W;
  localparam int ENTRY_W = 2 * (CNT_W + 1);

  // Entry layout: {coarse sign, coarse magnitude, fine sign, fine magnitude}.
  logic [ENTRY_W-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int COARSE = i / 2;
    localparam int FINE   = (i % 2 == 1) ? FINE_REPS : 0;
    assign table_q[i] = {1'b0, CNT_W'(COARSE), 1'b0, CNT_W'(FINE)};
  end

  assign {coarse_neg, coarse_mag, fine_neg, fine_mag} = table_q[idx];

endmodule

// File: rtl/c2r_control.sv
module c2r_control
  import c2r_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             coarse_neg,
  input  logic [CNT_W-1:0] coarse_mag,
  input  logic             fine_neg,
  input  logic [CNT_W-1:0] fine_mag,
  output logic             accept,
  output logic             busy,
  output logic             step_en,
  output logic             finish,
  output c2r_step_e        step_kind,
  output logic             step_neg
);

  c2r_state_e       state_q;
  logic [CNT_W-1:0] coarse_left_q, fine_left_q;
  logic             coarse_neg_q, fine_neg_q;
  logic             stop;
  logic [CNT_W:0]   remaining;

  assign busy      = (state_q == ST_RUN);
  assign accept    = (state_q == ST_IDLE) && start;
  assign stop      = (coarse_left_q == '0) && (fine_left_q == '0);
  assign step_kind = (coarse_left_q == '0) ? STEP_FINE : STEP_COARSE;
  assign step_neg  = (step_kind == STEP_FINE) ? fine_neg_q : coarse_neg_q;
  assign step_en   = busy && !stop;
  assign finish    = busy && stop;
  assign remaining = {1'b0, coarse_left_q} + {1'b0, fine_left_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      coarse_left_q <= '0;
      fine_left_q   <= '0;
      coarse_neg_q  <= 1'b0;
      fine_neg_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            coarse_left_q <= coarse_mag;
            fine_left_q   <= fine_mag;
            coarse_neg_q  <= coarse_neg;
            fine_neg_q    <= fine_neg;
            state_q       <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (stop) begin
            state_q <= ST_IDLE;
          end else if (coarse_left_q != '0) begin
            coarse_left_q <= coarse_left_q - 1'b1;
          end else begin
            fine_left_q <= fine_left_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: each running cycle consumes exactly one step.
  p_one_step_per_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (remaining == $past(remaining) - 1'b1));

  // R5: once the fine phase begins, no coarse step follows.
  p_coarse_before_fine_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_kind == STEP_FINE) |=> (step_kind == STEP_FINE));

  // R8: a running rotation is not left or reloaded before its steps are spent.
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
    step_en |=> busy);

endmodule

// File: rtl/c2r_scaler.sv
module c2r_scaler #(
  parameter int                 IN_W   = 18,
  parameter int                 OUT_W  = 17,
  parameter int                 FRAC_W = 8,
  parameter logic [FRAC_W-1:0]  MANT   = 8'b1011_0101
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] part [FRAC_W+1];
  logic                   too_big;

  assign part[0] = '0;

  // One shifted copy per set mantissa bit; bit FRAC_W-b weighs 2^-b.
  for (genvar b = 1; b <= FRAC_W; b++) begin : g_term
    if (MANT[FRAC_W-b]) begin : g_add
      assign part[b] = part[b-1] + (din >>> b);
    end else begin : g_skip
      assign part[b] = part[b-1];
    end
  end

  // Clamp on the range check instead of silently dropping high bits.
  assign too_big = (part[FRAC_W][IN_W-1:OUT_W-1] != {(IN_W-OUT_W+1){part[FRAC_W][IN_W-1]}});

  always_comb begin
    if (!too_big)                dout = part[FRAC_W][OUT_W-1:0];
    else if (part[FRAC_W] < 0)   dout = MIN_V;
    else                         dout = MAX_V;
  end

endmodule

// File: rtl/c2r_microrot.sv
module c2r_microrot
  import c2r_pkg::*;
#(
  parameter int W       = 17,
  parameter int FINE_SH = 3
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  c2r_step_e           kind,
  input  logic                neg,
  output logic signed [W-1:0] x_nxt,
  output logic signed [W-1:0] y_nxt
);

  localparam int SW = W + 1;

  logic signed [SW-1:0] xw, yw, cx_sum, cy_sum;
  logic signed [W-1:0]  cx, cy, fx, fy, y_sh, x_sh;

  assign xw = SW'(x);
  assign yw = SW'(y);

  // Coarse: clockwise (neg=0) adds y into x and subtracts x from y.
  assign cx_sum = neg ? (xw - yw) : (xw + yw);
  assign cy_sum = neg ? (yw + xw) : (yw - xw);

  c2r_scaler #(
    .IN_W  (SW),
    .OUT_W (W),
    .FRAC_W(C2R_GAIN_FRAC_W),
    .MANT  (C2R_GAIN_MANT)
  ) u_scale_x (
    .din (cx_sum),
    .dout(cx)
  );

  c2r_scaler #(
    .IN_W  (SW),
    .OUT_W (W),
    .FRAC_W(C2R_GAIN_FRAC_W),
    .MANT  (C2R_GAIN_MANT)
  ) u_scale_y (
    .din (cy_sum),
    .dout(cy)
  );

  // Fine: fixed shift, no gain correction.
  assign y_sh = y >>> FINE_SH;
  assign x_sh = x >>> FINE_SH;
  assign fx   = neg ? (x - y_sh) : (x + y_sh);
  assign fy   = neg ? (y + x_sh) : (y - x_sh);

  assign x_nxt = (kind == STEP_COARSE) ? cx : fx;
  assign y_nxt = (kind == STEP_COARSE) ? cy : fy;

endmodule

// File: rtl/c2r_rotator.sv
module c2r_rotator
  import c2r_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 3,
  parameter int FINE_SH   = 3,
  parameter int FINE_REPS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   y_in,
  output logic                done,
  output logic [DATA_W:0]     x_out,
  output logic [DATA_W:0]     y_out
);

  localparam int IW      = DATA_W + 1;
  localparam int CNT_MIN = $clog2(FINE_REPS + 1);
  localparam int CNT_W   = (IDX_W - 1 > CNT_MIN) ? IDX_W - 1 : CNT_MIN;

  logic             coarse_neg, fine_neg;
  logic [CNT_W-1:0] coarse_mag, fine_mag;
  logic             accept, busy, step_en, finish, step_neg;
  c2r_step_e        step_kind;

  logic signed [IW-1:0] xs_in, ys_in, x_q, y_q, x_nxt, y_nxt;

  assign xs_in = IW'($signed(x_in));
  assign ys_in = IW'($signed(y_in));

  c2r_count_table #(
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .FINE_REPS(FINE_REPS)
  ) u_table (
    .idx       (idx),
    .coarse_neg(coarse_neg),
    .coarse_mag(coarse_mag),
    .fine_neg  (fine_neg),
    .fine_mag  (fine_mag)
  );

  c2r_control #(
    .CNT_W(CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .coarse_neg(coarse_neg),
    .coarse_mag(coarse_mag),
    .fine_neg  (fine_neg),
    .fine_mag  (fine_mag),
    .accept    (accept),
    .busy      (busy),
    .step_en   (step_en),
    .finish    (finish),
    .step_kind (step_kind),
    .step_neg  (step_neg)
  );

  c2r_microrot #(
    .W      (IW),
    .FINE_SH(FINE_SH)
  ) u_rot (
    .x    (x_q),
    .y    (y_q),
    .kind (step_kind),
    .neg  (step_neg),
    .x_nxt(x_nxt),
    .y_nxt(y_nxt)
  );

  // Working vector.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (accept) begin
      x_q <= xs_in;
      y_q <= ys_in;
    end else if (step_en) begin
      x_q <= x_nxt;
      y_q <= y_nxt;
    end
  end

  // Registered result and completion pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      x_out <= '0;
      y_out <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        x_out <= x_q;
        y_out <= y_q;
      end
    end
  end

  // R7: completion is a single-cycle pulse.
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the result only moves together with done.
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(x_out) && $stable(y_out)));

  // R6: index 0 passes the sample through after one cycle.
  p_zero_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && idx == '0) |=> ##1
      (done && x_out == $past(xs_in, 2) && y_out == $past(ys_in, 2)));

  // R8: no request is taken while a rotation runs.
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);

endmodule

// File: tb/sim_c2r_rotator.sv
`timescale 1ns/1ps
module sim_c2r_rotator;

  localparam int DATA_W = 16;
  localparam int IDX_W  = 3;
  localparam int WD_CYC = 50000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  idx = '0;
  logic [DATA_W-1:0] x_in = '0, y_in = '0;
  logic              done;
  logic [DATA_W:0]   x_out, y_out;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0;
  bit busy_phase = 1'b0;

  // Reference model state.
  int    m_wait = 0, m_x = 0, m_y = 0, p_x = 0, p_y = 0;
  bit    m_done = 1'b0;
  string m_tag = "R1", p_tag = "R1";

  always #2.5 clk = ~clk;

  c2r_rotator #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .idx(idx),
    .x_in(x_in), .y_in(y_in), .done(done), .x_out(x_out), .y_out(y_out)
  );

  function automatic int gain(int v);
    return (v >>> 1) + (v >>> 3) + (v >>> 4) + (v >>> 6) + (v >>> 8);
  endfunction

  function automatic int steps_of(int i);
    return (i >> 1) + (((i & 1) != 0) ? 3 : 0);
  endfunction

  task automatic ref_rotate(input int i, input int xi, input int yi,
                            output int xo, output int yo);
    int a = xi, b = yi, t;
    for (int s = 0; s < (i >> 1); s++) begin   // R3 coarse steps first (R5)
      t = gain(a + b);
      b = gain(b - a);
      a = t;
    end
    if ((i & 1) != 0) begin
      for (int s = 0; s < 3; s++) begin         // R4 fine steps
        t = a + (b >>> 3);
        b = b - (a >>> 3);
        a = t;
      end
    end
    xo = a;
    yo = b;
  endtask

  // Cycle model: accepts when idle, counts down, then reports.
  always @(posedge clk) begin
    if (rst) begin
      m_wait = 0; m_done = 1'b0; m_x = 0; m_y = 0;
    end else begin
      m_done = 1'b0;
      if (m_wait == 0) begin
        if (start) begin
          ref_rotate(int'(idx), int'($signed(x_in)), int'($signed(y_in)), p_x, p_y);
          m_wait = steps_of(int'(idx)) + 1;
          if (busy_phase)            p_tag = "R8";
          else if (idx == 0)         p_tag = "R6";
          else if (idx[0])           p_tag = "R4 R5";
          else                       p_tag = "R3";
        end
      end else begin
        m_wait--;
        if (m_wait == 0) begin
          m_done = 1'b1; m_x = p_x; m_y = p_y; m_tag = p_tag;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (done !== m_done) begin
        n_fail++;
        $display("FAIL %s done timing (R2): actual=%0b expected=%0b", busy_phase ? "R8" : "R2", done, m_done);
      end
      n_chk++;
      if (int'($signed(x_out)) != m_x || int'($signed(y_out)) != m_y) begin
        n_fail++;
        $display("FAIL %s result: actual=(%0d,%0d) expected=(%0d,%0d)",
                 m_done ? m_tag : "R7", int'($signed(x_out)), int'($signed(y_out)), m_x, m_y);
      end
    end
  end

  task automatic request(input int i, input int xv, input int yv);
    start = 1'b1;
    idx   = IDX_W'(i);
    x_in  = DATA_W'(xv);
    y_in  = DATA_W'(yv);
    @(negedge clk);
    start = 1'b0;
    while (m_wait != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int xs[6] = '{1000, 0, 32767, -32768, -12345, 32767};
    int ys[6] = '{0, -2000, 32767, -32768, 6789, -32768};
    // R1: reset state.
    repeat (3) @(negedge clk);
    n_chk++;
    if (done !== 1'b0 || x_out !== '0 || y_out !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual=(%0b,%0h,%0h) expected=(0,0,0)", done, x_out, y_out);
    end
    rst = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;
    repeat (2) @(negedge clk);

    // R2..R6: every index with every sample, issued back to back.
    for (int i = 0; i < 8; i++)
      for (int v = 0; v < 6; v++)
        request(i, xs[v], ys[v]);
    repeat (3) @(negedge clk);

    // R8: start held high with changing operands.
    busy_phase = 1'b1;
    for (int c = 0; c < 40; c++) begin
      start = 1'b1;
      idx   = IDX_W'(7 - (c % 8));
      x_in  = DATA_W'(300 * c - 5000);
      y_in  = DATA_W'(7000 - 450 * c);
      @(negedge clk);
    end
    start = 1'b0;
    while (m_wait != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule